// File: doc/BRIEF.md
# Gated Quadrature Position Counter

This block turns two phase-shifted encoder tracks (A and B), a zero-mark track (C) and one general-purpose external input into a position count. The count can run across the full counter width or be confined to a 16-bit window.

There are three counting schemes:
- a four-edge quadrature scheme;
- a single-edge quadrature scheme;
- a pulse-and-direction scheme with a direction inversion bit.

The external input does two jobs. It can act as a level gate that freezes the count. It can also act as an edge source that clears the count. C can clear the count as well.

A host load pulse copies a set value into the counter. The load overrides everything else in that cycle.

Every input passes through a two-flop synchroniser. A and B can also pass through a selectable glitch filter. All four channels are then aligned to the same latency, so that events on different pins that occur together are seen together.

The block raises a sticky error flag when A and B change in the same sampled cycle in a quadrature scheme. A configuration error output shows when both clear sources are enabled at once.

Top module: `qpos_counter`

## Requirements
- R1: With `cfg_mode`=0 (four-edge), every change of A or B moves the count by one. On a change of A the count goes up when the new A differs from the new B. On a change of B the count goes up when the new A equals the new B. The sequence AB 00→10→11→01→00 (A leading) therefore counts up, and the reverse sequence counts down.
- R2: With `cfg_mode`=1 (single-edge), only rising edges of A move the count. The count goes up if B is 0 at that edge and down if B is 1. Falling edges of A and all edges of B leave the count unchanged.
- R3: With `cfg_mode`=2 (pulse/direction), each rising edge of A steps the count. The step is up when B is low and down when B is high, and `cfg_reverse`=1 swaps the two directions. With `cfg_mode`=3 no A or B activity moves the count.
- R4: Gate setting `cfg_gate` has four values. 0 means no gate. 1 freezes the count while the external input is high. 2 freezes it while the external input is low. 3 is treated as no gate. A and B activity during a freeze is lost and is not replayed.
- R5: With `cfg_c_clr_en`=1 and `cfg_x_clr_en`=0, a rising edge on C clears the count to zero. A falling edge on C does not clear it.
- R6: With `cfg_x_clr_en`=1 and `cfg_c_clr_en`=0, an edge of the external input clears the count. The edge is rising when `cfg_x_clr_rise`=1 and falling when it is 0. The opposite edge has no effect.
- R7: When both clear enables are set, neither C nor the external input clears the count, and `cfg_err` reads 1. `cfg_err` reads 0 otherwise.
- R8: When an external clear edge and a gate freeze begin in the same cycle, the count becomes zero. It then stays at zero while the freeze lasts.
- R9: With `cfg_narrow`=1, the count and every loaded value keep only their low 16 bits and the upper bits read as zero. Stepping wraps modulo 2^16, so 0xFFFF+1 gives 0 and 0−1 gives 0xFFFF.
- R10: In modes 0 and 1, a sampled cycle in which A and B both change does not move the count. It sets `err_illegal`, which stays set until reset.
- R11: A one-cycle `load` writes `load_val` into the count. The load wins over a clear, a gate freeze and a step that fall in the same cycle.
- R12: With `cfg_filt_en`=1, a level on A or B must persist for FILT_LEN (default 4) clock cycles before it is accepted. A pulse shorter than that does not move the count.
- R13: After reset, `count` is 0, `err_illegal` is 0 and `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder track A (asynchronous) |
| enc_b | input | 1 | Encoder track B (asynchronous) |
| enc_c | input | 1 | Zero-mark track C (asynchronous) |
| ext_in | input | 1 | External gate / clear input (asynchronous) |
| cfg_mode | input | 2 | 0 four-edge, 1 single-edge, 2 pulse/direction, 3 idle |
| cfg_reverse | input | 1 | Invert direction in pulse/direction mode |
| cfg_gate | input | 2 | 0 off, 1 freeze on high, 2 freeze on low, 3 off |
| cfg_c_clr_en | input | 1 | Enable clearing on a rising edge of C |
| cfg_x_clr_en | input | 1 | Enable clearing on an edge of the external input |
| cfg_x_clr_rise | input | 1 | 1 selects the rising external edge, 0 the falling edge |
| cfg_narrow | input | 1 | Confine the count to 16 bits |
| cfg_filt_en | input | 1 | Enable the glitch filter on A and B |
| load | input | 1 | Load strobe for the set value |
| load_val | input | CNT_W | Set value |
| count | output | CNT_W | Position count (two's complement) |
| err_illegal | output | 1 | Sticky flag for a simultaneous A and B change |
| cfg_err | output | 1 | Both clear sources enabled |

## Verification
The quadrature logic is tried with four patterns, each of which tells a different mistake apart:
- Forward and backward Gray sequences separate the two direction rules.
- The same sequences in single-edge mode show whether B edges and falling A edges are wrongly counted.
- Pulse trains under both levels of B, with and without the inversion bit, expose a swapped direction select.
- A jump from 00 to 11 shows whether a double change is counted or flagged.

Gating is driven with the external input at both levels under each polarity. Clears are driven on both edges of C and of the external input. Timed coincidences are set up between load and C, and between a clear edge and a gate freeze, to expose the priority order. A short pulse against a long one, with the filter enabled, checks that the filter threshold is honoured.

// File: rtl/qpos_pkg.sv
package qpos_pkg;

    // Channel positions inside the synchronised input bus
    localparam int CH_A   = 0;
    localparam int CH_B   = 1;
    localparam int CH_C   = 2;
    localparam int CH_X   = 3;
    localparam int N_CHAN = 4;

    typedef enum logic [1:0] {
        MODE_QUAD4    = 2'd0,
        MODE_SINGLE   = 2'd1,
        MODE_PULSEDIR = 2'd2,
        MODE_IDLE     = 2'd3
    } count_mode_e;

    typedef enum logic [1:0] {
        GATE_OFF       = 2'd0,
        GATE_HOLD_HIGH = 2'd1,
        GATE_HOLD_LOW  = 2'd2,
        GATE_RSVD      = 2'd3
    } gate_mode_e;

    // Per-cycle command from the decoder to the counter core
    typedef struct packed {
        logic step;
        logic up;
        logic clear;
        logic hold;
        logic illegal;
    } step_cmd_t;

endpackage

// File: rtl/qpos_sync.sv
module qpos_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '{default: '0};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/qpos_filter.sv
module qpos_filter
    import qpos_pkg::*;
#(
    parameter int LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              filt_en,
    input  logic [N_CHAN-1:0] raw,
    output logic [N_CHAN-1:0] lvl
);

    localparam int CW = $clog2(LEN + 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } fstate_t;

    for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
        fstate_t st_d, st_q;

        if (i == CH_A || i == CH_B) begin : g_filtered
            // Encoder tracks: accept a new level only after LEN cycles
            always_comb begin
                st_d = st_q;
                if (!filt_en) begin
                    st_d.lvl = raw[i];
                    st_d.cnt = '0;
                end else if (raw[i] == st_q.lvl) begin
                    st_d.cnt = '0;
                end else if (st_q.cnt == CW'(LEN - 1)) begin
                    st_d.lvl = raw[i];
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end else begin : g_plain
            // Other channels: one register so latency matches A and B
            always_comb begin
                st_d     = st_q;
                st_d.lvl = raw[i];
                st_d.cnt = '0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign lvl[i] = st_q.lvl;
    end

endmodule

// File: rtl/qpos_decode.sv
module qpos_decode
    import qpos_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CHAN-1:0] lvl,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_reverse,
    input  logic [1:0]        cfg_gate,
    input  logic              cfg_c_clr_en,
    input  logic              cfg_x_clr_en,
    input  logic              cfg_x_clr_rise,
    output step_cmd_t         cmd,
    output logic              err_illegal,
    output logic              cfg_err
);

    typedef struct packed {
        logic [N_CHAN-1:0] prev;
        logic              err;
        logic              cfg_err;
    } dec_state_t;

    dec_state_t st_d, st_q;

    logic a, b, c, x;
    logic a_chg, b_chg, a_rise, c_rise, x_rise, x_fall, conflict;

    always_comb begin
        a        = lvl[CH_A];
        b        = lvl[CH_B];
        c        = lvl[CH_C];
        x        = lvl[CH_X];
        a_chg    = a ^ st_q.prev[CH_A];
        b_chg    = b ^ st_q.prev[CH_B];
        a_rise   = a & ~st_q.prev[CH_A];
        c_rise   = c & ~st_q.prev[CH_C];
        x_rise   = x & ~st_q.prev[CH_X];
        x_fall   = ~x & st_q.prev[CH_X];
        conflict = cfg_c_clr_en & cfg_x_clr_en;

        cmd = '0;

        unique case (count_mode_e'(cfg_mode))
            MODE_QUAD4: begin
                if (a_chg && b_chg) begin
                    cmd.illegal = 1'b1;
                end else if (a_chg) begin
                    cmd.step = 1'b1;
                    cmd.up   = (a != b);
                end else if (b_chg) begin
                    cmd.step = 1'b1;
                    cmd.up   = (a == b);
                end
            end
            MODE_SINGLE: begin
                if (a_chg && b_chg) begin
                    cmd.illegal = 1'b1;
                end else if (a_rise) begin
                    cmd.step = 1'b1;
                    cmd.up   = ~b;
                end
            end
            MODE_PULSEDIR: begin
                if (a_rise) begin
                    cmd.step = 1'b1;
                    cmd.up   = ~b ^ cfg_reverse;
                end
            end
            default: begin
                cmd.step = 1'b0;
            end
        endcase

        cmd.clear = ~conflict &
                    ((cfg_c_clr_en & c_rise) |
                     (cfg_x_clr_en & (cfg_x_clr_rise ? x_rise : x_fall)));

        unique case (gate_mode_e'(cfg_gate))
            GATE_HOLD_HIGH: cmd.hold = x;
            GATE_HOLD_LOW:  cmd.hold = ~x;
            default:        cmd.hold = 1'b0;
        endcase

        st_d         = st_q;
        st_d.prev    = lvl;
        st_d.err     = st_q.err | cmd.illegal;
        st_d.cfg_err = conflict;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_illegal = st_q.err;
    assign cfg_err     = st_q.cfg_err;

    // R10: the illegal-transition flag never drops once raised
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err)
        else $error("p_err_sticky_r10");

    // R10: an illegal transition is visible on the flag one cycle later
    p_err_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.illegal |=> err_illegal)
        else $error("p_err_raise_r10");

endmodule

// File: rtl/qpos_core.sv
module qpos_core
    import qpos_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_cmd_t        cmd,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             narrow,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] NMASK = (CNT_W'(1) << NARROW_W) - CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [CNT_W-1:0] raw_next;

    always_comb begin
        // Priority: load, then clear, then gate freeze, then step
        if (load) begin
            raw_next = load_val;
        end else if (cmd.clear) begin
            raw_next = '0;
        end else if (cmd.hold) begin
            raw_next = st_q.cnt;
        end else if (cmd.step) begin
            raw_next = cmd.up ? st_q.cnt + 1'b1 : st_q.cnt - 1'b1;
        end else begin
            raw_next = st_q.cnt;
        end
        st_d.cnt = narrow ? (raw_next & NMASK) : raw_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

    // R11: a load lands in the count on the next cycle
    p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !narrow) |=> count == $past(load_val))
        else $error("p_load_r11");

    // R5: a clear without a load yields zero
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.clear && !load) |=> count == '0)
        else $error("p_clear_r5");

    // R4: a freeze keeps the count unchanged
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.hold && !load && !cmd.clear && !narrow) |=> $stable(count))
        else $error("p_hold_r4");

    // R1: an up step adds exactly one
    p_step_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.step && cmd.up && !load && !cmd.clear && !cmd.hold && !narrow)
        |=> count == $past(count) + 1'b1)
        else $error("p_step_up_r1");

    // R10: an illegal transition does not move the count
    p_illegal_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.illegal && !load && !cmd.clear && !narrow) |=> $stable(count))
        else $error("p_illegal_still_r10");

    if (CNT_W > NARROW_W) begin : g_narrow_chk
        // R9: upper bits stay clear in narrow mode
        p_narrow_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
            narrow |=> (count & ~NMASK) == '0)
            else $error("p_narrow_upper_r9");
    end

endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
    import qpos_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int NARROW_W    = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_c,
    input  logic             ext_in,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_reverse,
    input  logic [1:0]       cfg_gate,
    input  logic             cfg_c_clr_en,
    input  logic             cfg_x_clr_en,
    input  logic             cfg_x_clr_rise,
    input  logic             cfg_narrow,
    input  logic             cfg_filt_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             err_illegal,
    output logic             cfg_err
);

    logic [N_CHAN-1:0] pins;
    logic [N_CHAN-1:0] synced;
    logic [N_CHAN-1:0] levels;
    step_cmd_t         cmd;

    always_comb begin
        pins       = '0;
        pins[CH_A] = enc_a;
        pins[CH_B] = enc_b;
        pins[CH_C] = enc_c;
        pins[CH_X] = ext_in;
    end

    qpos_sync #(
        .W      (N_CHAN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins),
        .dout  (synced)
    );

    qpos_filter #(
        .LEN (FILT_LEN)
    ) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .filt_en (cfg_filt_en),
        .raw     (synced),
        .lvl     (levels)
    );

    qpos_decode u_decode (
        .clk            (clk),
        .rst_n          (rst_n),
        .lvl            (levels),
        .cfg_mode       (cfg_mode),
        .cfg_reverse    (cfg_reverse),
        .cfg_gate       (cfg_gate),
        .cfg_c_clr_en   (cfg_c_clr_en),
        .cfg_x_clr_en   (cfg_x_clr_en),
        .cfg_x_clr_rise (cfg_x_clr_rise),
        .cmd            (cmd),
        .err_illegal    (err_illegal),
        .cfg_err        (cfg_err)
    );

    qpos_core #(
        .CNT_W    (CNT_W),
        .NARROW_W (NARROW_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .load     (load),
        .load_val (load_val),
        .narrow   (cfg_narrow),
        .count    (count)
    );

    // R7: with both clear sources enabled, the count is never cleared by them
    p_conflict_noclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_c_clr_en && cfg_x_clr_en) |-> !cmd.clear)
        else $error("p_conflict_noclr_r7");

endmodule

// File: tb/sim_qpos_counter.sv
module sim_qpos_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_c = 1'b0, ext_in = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_reverse = 1'b0;
    logic [1:0]  cfg_gate = 2'd0;
    logic        cfg_c_clr_en = 1'b0, cfg_x_clr_en = 1'b0, cfg_x_clr_rise = 1'b0;
    logic        cfg_narrow = 1'b0, cfg_filt_en = 1'b0;
    logic        load = 1'b0;
    logic [31:0] load_val = '0;
    logic [31:0] count;
    logic        err_illegal, cfg_err;

    qpos_counter u0 (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_c(enc_c),
        .ext_in(ext_in), .cfg_mode(cfg_mode), .cfg_reverse(cfg_reverse),
        .cfg_gate(cfg_gate), .cfg_c_clr_en(cfg_c_clr_en),
        .cfg_x_clr_en(cfg_x_clr_en), .cfg_x_clr_rise(cfg_x_clr_rise),
        .cfg_narrow(cfg_narrow), .cfg_filt_en(cfg_filt_en), .load(load),
        .load_val(load_val), .count(count), .err_illegal(err_illegal),
        .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [31:0] cnt;
        logic        err;
        logic        cerr;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    event        chk_ev;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_cnt = '0;
    logic        exp_err = 1'b0;
    logic        exp_cerr = 1'b0;
    bit          done = 1'b0;

    // Monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            exp_t it;
            @(chk_ev);
            @(negedge clk);
            it = sb_q.pop_front();
            checks++;
            if (count !== it.cnt || err_illegal !== it.err || cfg_err !== it.cerr) begin
                errors++;
                $display("FAIL %s: count=%h err=%b cfg_err=%b expected count=%h err=%b cfg_err=%b",
                         it.tag, count, err_illegal, cfg_err, it.cnt, it.err, it.cerr);
            end
        end
    end

    task automatic settle();
        repeat (10) @(posedge clk);
        #1;
    endtask

    task automatic expect_now(input string tag);
        exp_t it;
        it.cnt  = exp_cnt;
        it.err  = exp_err;
        it.cerr = exp_cerr;
        it.tag  = tag;
        sb_q.push_back(it);
        ->chk_ev;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic drive_ab(input logic a, input logic b);
        enc_a = a;
        enc_b = b;
        settle();
    endtask

    task automatic fwd(input int n);
        for (int i = 0; i < n; i++) drive_ab(~enc_b, enc_a);
    endtask

    task automatic rev(input int n);
        for (int i = 0; i < n; i++) drive_ab(enc_b, ~enc_a);
    endtask

    task automatic pulse_a(input int n);
        for (int i = 0; i < n; i++) begin
            enc_a = 1'b1; settle();
            enc_a = 1'b0; settle();
        end
    endtask

    task automatic do_load(input logic [31:0] v);
        load_val = v;
        load = 1'b1;
        @(posedge clk); #1;
        load = 1'b0;
        settle();
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();
        expect_now("R13 reset state");

        // R1 four-edge quadrature
        fwd(8);  exp_cnt = 8;  expect_now("R1 forward");
        rev(4);  exp_cnt = 4;  expect_now("R1 backward");

        // R2 single-edge
        cfg_mode = 2'd1;
        fwd(4);  exp_cnt = 5;  expect_now("R2 forward counts A rise only");
        rev(4);  exp_cnt = 4;  expect_now("R2 backward counts A rise only");

        // R3 pulse/direction
        cfg_mode = 2'd2;
        pulse_a(3); exp_cnt = 7; expect_now("R3 B low up");
        drive_ab(1'b0, 1'b1);
        pulse_a(2); exp_cnt = 5; expect_now("R3 B high down");
        cfg_reverse = 1'b1;
        pulse_a(1); exp_cnt = 6; expect_now("R3 reverse bit");
        cfg_reverse = 1'b0;
        cfg_mode = 2'd3;
        pulse_a(2); drive_ab(1'b0, 1'b0);
        expect_now("R3 idle mode no count");

        // R4 gate
        cfg_mode = 2'd0;
        cfg_gate = 2'd1; ext_in = 1'b1; settle();
        fwd(4); expect_now("R4 hold on high");
        ext_in = 1'b0; settle();
        fwd(2); exp_cnt = 8; expect_now("R4 release on low");
        cfg_gate = 2'd2; settle();
        fwd(2); expect_now("R4 hold on low");
        ext_in = 1'b1; settle();
        fwd(2); exp_cnt = 10; expect_now("R4 release on high");
        cfg_gate = 2'd0; ext_in = 1'b0; settle();
        rev(2); exp_cnt = 8; expect_now("R4 gate off");

        // R11 load
        do_load(32'h1234_5678); exp_cnt = 32'h1234_5678; expect_now("R11 load");

        // R5 C clear
        cfg_c_clr_en = 1'b1;
        fwd(1); exp_cnt = 32'h1234_5679;
        enc_c = 1'b1; settle(); exp_cnt = 0; expect_now("R5 C rise clears");
        enc_c = 1'b0; settle();
        fwd(1); exp_cnt = 1; expect_now("R5 C fall no clear");

        // R11 load coincides with C clear
        load_val = 32'hCAFE_0000;
        enc_c = 1'b1;
        repeat (3) @(posedge clk);
        #1 load = 1'b1;
        @(posedge clk); #1 load = 1'b0;
        settle();
        exp_cnt = 32'hCAFE_0000; expect_now("R11 load beats clear");
        enc_c = 1'b0; settle();
        cfg_c_clr_en = 1'b0;

        // R6 external clear polarity
        cfg_x_clr_en = 1'b1; cfg_x_clr_rise = 1'b0;
        ext_in = 1'b1; settle(); expect_now("R6 rise ignored when falling chosen");
        ext_in = 1'b0; settle(); exp_cnt = 0; expect_now("R6 falling edge clears");
        cfg_x_clr_rise = 1'b1;
        fwd(1); exp_cnt = 1;
        ext_in = 1'b1; settle(); exp_cnt = 0; expect_now("R6 rising edge clears");
        ext_in = 1'b0; settle();

        // R7 both enables
        cfg_c_clr_en = 1'b1; settle(); exp_cerr = 1'b1;
        fwd(1); exp_cnt = 1;
        enc_c = 1'b1; settle(); enc_c = 1'b0; settle();
        ext_in = 1'b1; settle(); ext_in = 1'b0; settle();
        expect_now("R7 conflict no clear");
        cfg_c_clr_en = 1'b0; settle(); exp_cerr = 1'b0;

        // R8 clear then hold
        cfg_gate = 2'd1;
        fwd(2); exp_cnt = 3;
        ext_in = 1'b1; settle(); exp_cnt = 0;
        fwd(2); expect_now("R8 cleared and held");
        ext_in = 1'b0; settle();
        cfg_gate = 2'd0; cfg_x_clr_en = 1'b0;

        // R9 narrow
        cfg_narrow = 1'b1;
        do_load(32'h0000_FFFF); exp_cnt = 32'h0000_FFFF; expect_now("R9 narrow load");
        fwd(1); exp_cnt = 0; expect_now("R9 wrap up");
        rev(1); exp_cnt = 32'h0000_FFFF; expect_now("R9 wrap down");
        do_load(32'hABCD_0001); exp_cnt = 32'h0000_0001; expect_now("R9 load masked");
        cfg_narrow = 1'b0;

        // R12 filter
        cfg_filt_en = 1'b1; settle();
        enc_a = 1'b1;
        repeat (2) @(posedge clk);
        #1 enc_a = 1'b0;
        settle(); expect_now("R12 short pulse rejected");
        fwd(1); exp_cnt = 2; expect_now("R12 long level accepted");
        rev(1); exp_cnt = 1;
        cfg_filt_en = 1'b0; settle();

        // R10 illegal transition
        drive_ab(1'b1, 1'b1); exp_err = 1'b1; expect_now("R10 double change flagged");
        rev(1); exp_cnt = 0; expect_now("R10 flag sticky, counting resumes");
        rev(1); exp_cnt = 32'hFFFF_FFFF; expect_now("R10 below zero");

        // R13 reset again
        rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        settle();
        exp_cnt = 0; exp_err = 1'b0; expect_now("R13 reset clears flag");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule